// File: doc/BRIEF.md
# Clock Divider with Gated Sync Realignment

This block divides an input clock by a programmable ratio and produces a one-cycle enable tick at the divided rate. An external, asynchronous sync pulse can realign the divider phase. The divider counter returns to zero, so the next tick lands at a known cycle relative to the pulse.

A small control register decides which pulses are allowed through. A master switch must be on for any sync function to act. A divider-sync switch gates pulses to the counter. A one-shot selector picks between two behaviours. In continuous mode every pulse realigns the divider. In one-shot mode only the first pulse is taken, and the hardware then clears the divider-sync switch itself, so software needs no extra write to ignore later pulses.

The raw sync input passes through a two-flop synchroniser and a rising-edge detector. A pulse counts once however long it stays high. The divide ratio comes from a separate 3-bit select input and ranges from 1 to 8.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: After reset the control readback `ctrl_o` is 0x01 (master on, divider-sync off, one-shot off) and `div_tick_o` is high in the first cycle.
- R2: A write (`wr_en_i` high) stores `wr_data_i[2:0]` as the control bits: bit 0 master enable, bit 1 divider-sync enable, bit 2 one-shot. `ctrl_o[7:3]` always reads zero, whatever was written.
- R3: With bit 0 low, no sync pulse changes the divider phase or the control bits, whatever bit 1 holds.
- R4: With bit 0 high and bit 1 low, no sync pulse changes the divider phase.
- R5: With bits 0 and 1 high and bit 2 low, every sync rising edge realigns the divider, and bit 1 stays set.
- R6: With bits 0, 1 and 2 high, the first sync rising edge realigns the divider and clears bit 1. Later pulses have no effect on the phase.
- R7: The rising edge of `sync_i` is sampled by two flops and then edge-detected. If `sync_i` rises before clock edge k, the divider counter is zeroed at edge k+2, and `div_tick_o` is high in the cycle after edge k+2. A pulse held high for many cycles realigns only once.
- R8: `div_tick_o` pulses once every `div_sel_i`+1 cycles. With `div_sel_i` = 0 it is high on every cycle.
- R9: If a register write coincides with the hardware clear of bit 1, bit 1 ends up clear and bits 0 and 2 take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| sync_i | input | 1 | Raw asynchronous sync input |
| div_sel_i | input | 3 | Divide ratio minus one |
| div_tick_o | output | 1 | Divided clock enable tick |
| ctrl_o | output | 8 | Control register readback |

## Verification
The hardest case to reach is a register write that lands on exactly the clock edge where an armed one-shot accepts its pulse and clears bit 1. That edge is two cycles after the raw input rises. The bench raises `sync_i`, waits two cycles, and times a write on the accepting edge that sets bit 1 again. It then confirms that bit 1 ends up clear. Long-held pulses and re-armed one-shots are also produced by random stimulus. Each random run is compared cycle by cycle against a reference model in the bench.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;
  localparam int CTRL_W     = 8;
  localparam int CTRL_BITS  = 3;
  localparam logic [CTRL_BITS-1:0] CTRL_RST = 3'b001;

  // packed order puts one_shot at bit 2, div_en at bit 1, master at bit 0
  typedef struct packed {
    logic one_shot;
    logic div_en;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  AST_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/sync_ctrl_reg.sv
module sync_ctrl_reg
  import clkdiv_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              rise_i,
  output ctrl_t             ctrl_o,
  output logic              accept_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  unused_rsv;

  assign unused_rsv = ^wr_data_i[CTRL_W-1:CTRL_BITS];
  assign accept_o   = rise_i & ctrl_q.master & ctrl_q.div_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
    // hardware self-clear overrides a same-cycle write
    if (accept_o && ctrl_q.one_shot) ctrl_d.div_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= ctrl_t'(CTRL_RST);
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_ONESHOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && ctrl_q.one_shot) |=> !ctrl_q.div_en); // R6
  AST_COLLIDE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && ctrl_q.one_shot && wr_en_i) |=> (!ctrl_q.div_en && ctrl_q.master == $past(wr_data_i[0]))); // R9
  AST_NO_MASTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.master && !wr_en_i) |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             realign_i,
  output logic             tick_o
);
  logic [SEL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (realign_i)          cnt_q <= '0;
    else if (cnt_q >= div_sel_i) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl
  import clkdiv_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              sync_i,
  input  logic [SEL_W-1:0]  div_sel_i,
  output logic              div_tick_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int RSV_W = CTRL_W - CTRL_BITS;

  logic  rise, accept;
  ctrl_t ctrl;

  sync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_i),
    .rise_o (rise)
  );

  sync_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rise_i   (rise),
    .ctrl_o   (ctrl),
    .accept_o (accept)
  );

  div_counter #(.SEL_W(SEL_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_i),
    .realign_i(accept),
    .tick_o   (div_tick_o)
  );

  assign ctrl_o = {{RSV_W{1'b0}}, ctrl};

  AST_ACCEPT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> div_tick_o); // R5
  AST_RATIO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i == '0) |=> div_tick_o); // R8
endmodule

// File: tb/tb_clkdiv_sync_ctrl.sv
module tb_clkdiv_sync_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sync = 1'b0;
  logic [2:0] div_sel = 3'd3;
  logic       tick;
  logic [7:0] ctrl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic       m_s1, m_s2, m_s3;
  logic [2:0] m_ctrl;
  logic [2:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_sync_ctrl dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .sync_i    (sync),
    .div_sel_i (div_sel),
    .div_tick_o(tick),
    .ctrl_o    (ctrl)
  );

  function automatic logic [2:0] next_cnt(logic acc, logic [2:0] c, logic [2:0] sel);
    if (acc)             return 3'd0;
    else if (c >= sel)   return 3'd0;
    else                 return c + 3'd1;
  endfunction

  function automatic logic [2:0] next_ctrl(logic acc, logic [2:0] c, logic we, logic [7:0] d);
    logic [2:0] n;
    n = we ? d[2:0] : c;
    if (acc && c[2]) n[1] = 1'b0;
    return n;
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ctrl = 3'b001; m_cnt = 3'd0;
  endtask

  task automatic model_step();
    logic acc;
    acc    = m_s2 & ~m_s3 & m_ctrl[0] & m_ctrl[1];
    m_ctrl = next_ctrl(acc, m_ctrl, wr_en, wr_data);
    m_cnt  = next_cnt(acc, m_cnt, div_sel);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    check(req, {7'd0, tick}, {7'd0, (m_cnt == 3'd0)});
    check(req, ctrl, {5'd0, m_ctrl});
  endtask

  // one cycle: inputs set after negedge, model updated at posedge, compared at next negedge
  task automatic cyc(string req, logic we, logic [7:0] d, logic s);
    wr_en = we; wr_data = d; sync = s;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(string req, int n, logic s);
    for (int i = 0; i < n; i++) cyc(req, 1'b0, 8'h00, s);
  endtask

  task automatic pulse(string req, int width, int gap);
    idle(req, width, 1'b1);
    idle(req, gap, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    #(CLK_PERIOD * 2 + 3);
    @(negedge clk);
    check("R1", ctrl, 8'h01);
    check("R1", {7'd0, tick}, 8'h01);
    rst_n = 1'b1;

    // R2: reserved bits read zero
    cyc("R2", 1'b1, 8'hF8, 1'b0);
    check("R2", ctrl, 8'h00);
    cyc("R2", 1'b1, 8'hFD, 1'b0);
    check("R2", ctrl, 8'h05);

    // R3: master off, divider-sync on
    div_sel = 3'd5;
    cyc("R3", 1'b1, 8'h02, 1'b0);
    idle("R3", 3, 1'b0);
    pulse("R3", 2, 6);
    pulse("R3", 1, 5);
    check("R3", ctrl, 8'h02);

    // R4: master on, divider-sync off
    cyc("R4", 1'b1, 8'h05, 1'b0);
    pulse("R4", 3, 7);
    check("R4", ctrl, 8'h05);

    // R5: continuous mode
    div_sel = 3'd7;
    cyc("R5", 1'b1, 8'h03, 1'b0);
    idle("R5", 2, 1'b0);
    pulse("R5", 1, 9);
    pulse("R5", 2, 4);
    pulse("R5", 1, 11);
    check("R5", ctrl, 8'h03);

    // R7: timing of realignment and long pulse counted once
    idle("R7", 3, 1'b0);
    cyc("R7", 1'b0, 8'h00, 1'b1);   // rises before edge k
    cyc("R7", 1'b0, 8'h00, 1'b1);   // edge k+1
    cyc("R7", 1'b0, 8'h00, 1'b1);   // edge k+2: counter zeroed
    check("R7", {7'd0, tick}, 8'h01);
    cyc("R7", 1'b0, 8'h00, 1'b1);
    check("R7", {7'd0, tick}, 8'h00);
    idle("R7", 20, 1'b1);
    idle("R7", 4, 1'b0);

    // R6: one-shot
    cyc("R6", 1'b1, 8'h07, 1'b0);
    idle("R6", 3, 1'b0);
    pulse("R6", 1, 6);
    check("R6", ctrl, 8'h05);
    pulse("R6", 2, 6);
    pulse("R6", 1, 9);
    check("R6", ctrl, 8'h05);

    // R9: write on the self-clear edge
    cyc("R9", 1'b1, 8'h07, 1'b0);
    idle("R9", 3, 1'b0);
    cyc("R9", 1'b0, 8'h00, 1'b1);
    cyc("R9", 1'b0, 8'h00, 1'b1);
    cyc("R9", 1'b1, 8'hFE, 1'b1);
    check("R9", ctrl, 8'h04);
    cyc("R9", 1'b1, 8'hFB, 1'b0);
    check("R9", ctrl, 8'h03);
    idle("R9", 4, 1'b0);

    // R8: all ratios, including 1
    for (int r = 0; r < 8; r++) begin
      div_sel = 3'(r);
      idle("R8", 20, 1'b0);
    end
    div_sel = 3'd0;
    idle("R8", 5, 1'b0);
    check("R8", {7'd0, tick}, 8'h01);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [7:0] d;
      logic s;
      we = ($urandom_range(0, 15) == 0);
      d  = 8'($urandom);
      if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
      s  = ($urandom_range(0, 4) == 0) ? ~sync : sync;
      if ($urandom_range(0, 199) == 0) div_sel = 3'($urandom_range(0, 7));
      cyc("R5", we, d, s);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule